// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller with Row Refresh

This block connects a single-beat synchronous host port to a DRAM organised as 2048 rows by 2048 columns of 4-bit words, for 4,194,304 words in all. The host presents a 22-bit word address with a valid/ready handshake. The controller passes that address to the device over 11 shared pins in two halves. The upper 11 bits go out as the row and are latched by the row strobe. The lower 11 bits follow as the column and are latched by the column strobe. The controller also drives the chip-enable, output-enable and write-enable strobes. The 4-bit data bus is bidirectional, so it is split into an output value, a drive enable and an input value.

Cell charge leaks, so a timer raises a refresh request at a fixed period. The request is served by a row-strobe-only cycle, which makes the device read and rewrite one whole row. A counter walks through every row in turn. While a refresh is waiting or running the host sees ready low. A refresh only starts between host transfers.

All device strobes are active low. One transfer runs at a time, with no bursts and no page mode.

Top module: `mxdram_ctrl`

## Requirements
- R1: After reset, every device strobe (memRasN, memCasN, memWeN, memOeN, memCeN) is high, memDqDrive is 0, rdValid is 0 and reqReady is 1.
- R2: A host transfer first puts addr[21:11] on memAddr and lowers memRasN. It then puts addr[10:0] on memAddr and lowers memCasN. memCasN is never low while memRasN is high.
- R3: On a write (reqWrite=1), memWeN is low and memDqDrive is 1 with memDqOut equal to the write data one cycle before memCasN falls, and both stay so while memCasN is low.
- R4: On a read, memOeN is low only while memCasN is low. memDqIn is sampled READ_LAT cycles after memCasN falls. rdValid is a one-cycle pulse carrying that value, and it appears READ_LAT+3 cycles after the clock edge that accepted the request.
- R5: A request is accepted on a clock edge where reqValid and reqReady are both 1. reqReady is 0 from the cycle after acceptance until the transfer has ended, including one precharge cycle with all strobes high.
- R6: Every REFRESH_PERIOD cycles a refresh becomes pending. A refresh is a memRasN-low cycle lasting REF_HOLD cycles, during which memCasN, memWeN and memOeN stay high.
- R7: Successive refreshes present row numbers 0, 1, 2, … on memAddr. After row 2047 the sequence wraps to 0.
- R8: A pending refresh drives reqReady low and wins over a waiting host request. It never starts inside a host strobe sequence, so reqReady is 0 whenever memRasN is low.
- R9: memCeN is low for the whole of every device cycle, host or refresh, and high when the controller is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Host request valid |
| reqReady | output | 1 | Controller can accept a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 22 | Word address, row in [21:11], column in [10:0] |
| reqWdata | input | 4 | Write data |
| rdData | output | 4 | Read data |
| rdValid | output | 1 | One-cycle pulse when rdData is valid |
| memAddr | output | 11 | Multiplexed row/column address pins |
| memRasN | output | 1 | Row strobe, active low |
| memCasN | output | 1 | Column strobe, active low |
| memCeN | output | 1 | Chip enable, active low |
| memOeN | output | 1 | Output enable, active low |
| memWeN | output | 1 | Write enable, active low |
| memDqOut | output | 4 | Data driven to the device |
| memDqDrive | output | 1 | 1 when memDqOut drives the data bus |
| memDqIn | input | 4 | Data returned by the device |

## Verification
The bench drives a device model that latches the row on the falling row strobe and the column on the falling column strobe. It checks the latched pair against the host address, so a design that swapped or shifted the address halves would be caught even if it read back what it wrote. Read results go through a scoreboard that checks both the data and the exact latency. A capture taken one cycle early or late would return stale bus data or arrive at the wrong cycle.

A flood of back-to-back transfers runs while refreshes fall due. A design that let a refresh cut into a strobe sequence would show the row strobe low with ready high, or would corrupt data. The test then runs long enough for the refresh row counter to pass 2047. A counter that skipped rows or did not wrap would break the expected row sequence.

// File: rtl/mxdram_pkg.sv
package mxdram_pkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic accept;      // latch the host request
    logic selCol;      // put the column half on the pins
    logic selRef;      // put the refresh row on the pins
    logic driveData;   // drive write data onto the bus
    logic capture;     // sample read data this edge
    logic refAdvance;  // step the refresh row counter
  } dpCtrl_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ROW, ST_RAS, ST_COL, ST_CAS, ST_PRE, ST_RROW, ST_RRAS
  } seqState_t;

endpackage

// File: rtl/mxdram_seq.sv
module mxdram_seq
  import mxdram_pkg::*;
#(
  parameter int READ_LAT       = 2,
  parameter int REF_HOLD       = 2,
  parameter int REFRESH_PERIOD = 780
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  output logic    reqReady,
  output dpCtrl_t ctl,
  output logic    rasN,
  output logic    casN,
  output logic    ceN,
  output logic    oeN,
  output logic    weN
);

  localparam int MAXHOLD = (READ_LAT > REF_HOLD) ? READ_LAT : REF_HOLD;
  localparam int CW      = $clog2(MAXHOLD + 1);
  localparam int TW      = $clog2(REFRESH_PERIOD + 1);

  seqState_t state, stateNxt;
  logic [CW-1:0] cnt;
  logic [TW-1:0] refTimer;
  logic refPending;
  logic isWrite;
  logic lastRead, lastRef;

  assign lastRead = (cnt == CW'(READ_LAT - 1));
  assign lastRef  = (cnt == CW'(REF_HOLD - 1));

  // Refresh timer: sticky pending flag, cleared when the refresh starts
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refTimer   <= '0;
      refPending <= 1'b0;
    end else begin
      if (refTimer == TW'(REFRESH_PERIOD - 1)) begin
        refTimer   <= '0;
        refPending <= 1'b1;
      end else begin
        refTimer <= refTimer + 1'b1;
        if (state == ST_IDLE && refPending) refPending <= 1'b0;
      end
    end
  end

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE: begin
        if (refPending)    stateNxt = ST_RROW;
        else if (reqValid) stateNxt = ST_ROW;
      end
      ST_ROW:  stateNxt = ST_RAS;
      ST_RAS:  stateNxt = ST_COL;
      ST_COL:  stateNxt = ST_CAS;
      ST_CAS:  if (isWrite || lastRead) stateNxt = ST_PRE;
      ST_PRE:  stateNxt = ST_IDLE;
      ST_RROW: stateNxt = ST_RRAS;
      ST_RRAS: if (lastRef) stateNxt = ST_PRE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      isWrite <= 1'b0;
    end else begin
      state <= stateNxt;
      if (ctl.accept) isWrite <= reqWrite;
      if (state != stateNxt) cnt <= '0;
      else                   cnt <= cnt + 1'b1;
    end
  end

  logic hostCol, rasLow;
  assign hostCol = (state == ST_COL) || (state == ST_CAS);
  assign rasLow  = (state == ST_RAS) || hostCol || (state == ST_RRAS);

  assign reqReady = (state == ST_IDLE) && !refPending;
  assign ceN      = (state == ST_IDLE);
  assign rasN     = !rasLow;
  assign casN     = (state != ST_CAS);
  assign weN      = !(isWrite && hostCol);
  assign oeN      = !(!isWrite && state == ST_CAS);

  always_comb begin
    ctl            = '0;
    ctl.accept     = reqReady && reqValid;
    ctl.selCol     = hostCol;
    ctl.selRef     = (state == ST_RROW) || (state == ST_RRAS);
    ctl.driveData  = isWrite && hostCol;
    ctl.capture    = (state == ST_CAS) && !isWrite && lastRead;
    ctl.refAdvance = (state == ST_RRAS) && lastRef;
  end

  // R2: column strobe only inside a row-strobe window
  p_cas_inside_ras_r2: assert property (@(posedge clk) disable iff (!rstN)
    !casN |-> !rasN);
  // R3: write enable already low the cycle before the column strobe falls
  p_we_before_cas_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(casN) && !weN) |-> $past(!weN));
  // R4: output enable only while the column strobe is low
  p_oe_in_cas_r4: assert property (@(posedge clk) disable iff (!rstN)
    !oeN |-> !casN);
  // R5: no second acceptance straight after one
  p_ready_drops_r5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);
  // R6: refresh cycles keep the column, write and output strobes idle
  p_ref_ras_only_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.selRef |-> (casN && weN && oeN));
  // R8: host never sees ready while the row strobe is low
  p_busy_in_ras_r8: assert property (@(posedge clk) disable iff (!rstN)
    !rasN |-> !reqReady);
  // R9: chip enable covers every row-strobe cycle
  p_ce_cover_r9: assert property (@(posedge clk) disable iff (!rstN)
    !rasN |-> !ceN);

endmodule

// File: rtl/mxdram_datapath.sv
module mxdram_datapath
  import mxdram_pkg::*;
#(
  parameter int ROW_BITS  = 11,
  parameter int COL_BITS  = 11,
  parameter int DATA_BITS = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  dpCtrl_t                       ctl,
  input  logic [ROW_BITS+COL_BITS-1:0]  reqAddr,
  input  logic [DATA_BITS-1:0]          reqWdata,
  output logic [(ROW_BITS > COL_BITS ? ROW_BITS : COL_BITS)-1:0] memAddr,
  output logic [DATA_BITS-1:0]          memDqOut,
  output logic                          memDqDrive,
  input  logic [DATA_BITS-1:0]          memDqIn,
  output logic [DATA_BITS-1:0]          rdData,
  output logic                          rdValid
);

  localparam int AW   = ROW_BITS + COL_BITS;
  localparam int PINS = (ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS;

  logic [AW-1:0]        addrQ;
  logic [DATA_BITS-1:0] wdataQ;
  logic [ROW_BITS-1:0]  refRow;
  logic [PINS-1:0]      rowPins, colPins, refPins;

  assign rowPins = PINS'(addrQ[AW-1:COL_BITS]);
  assign colPins = PINS'(addrQ[COL_BITS-1:0]);
  assign refPins = PINS'(refRow);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ   <= '0;
      wdataQ  <= '0;
      refRow  <= '0;
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      if (ctl.accept) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
      end
      if (ctl.refAdvance) refRow <= refRow + 1'b1;
      if (ctl.capture) rdData <= memDqIn;
      rdValid <= ctl.capture;
    end
  end

  always_comb begin
    if (ctl.selRef)      memAddr = refPins;
    else if (ctl.selCol) memAddr = colPins;
    else                 memAddr = rowPins;
  end

  assign memDqOut   = wdataQ;
  assign memDqDrive = ctl.driveData;

  // R4: read data valid is a single-cycle pulse
  p_rdvalid_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);

endmodule

// File: rtl/mxdram_ctrl.sv
module mxdram_ctrl
  import mxdram_pkg::*;
#(
  parameter int ROW_BITS       = 11,
  parameter int COL_BITS       = 11,
  parameter int DATA_BITS      = 4,
  parameter int READ_LAT       = 2,
  parameter int REF_HOLD       = 2,
  parameter int REFRESH_PERIOD = 780
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         reqValid,
  output logic                         reqReady,
  input  logic                         reqWrite,
  input  logic [ROW_BITS+COL_BITS-1:0] reqAddr,
  input  logic [DATA_BITS-1:0]         reqWdata,
  output logic [DATA_BITS-1:0]         rdData,
  output logic                         rdValid,
  output logic [(ROW_BITS > COL_BITS ? ROW_BITS : COL_BITS)-1:0] memAddr,
  output logic                         memRasN,
  output logic                         memCasN,
  output logic                         memCeN,
  output logic                         memOeN,
  output logic                         memWeN,
  output logic [DATA_BITS-1:0]         memDqOut,
  output logic                         memDqDrive,
  input  logic [DATA_BITS-1:0]         memDqIn
);

  dpCtrl_t ctl;

  mxdram_seq #(
    .READ_LAT(READ_LAT), .REF_HOLD(REF_HOLD), .REFRESH_PERIOD(REFRESH_PERIOD)
  ) u_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .ctl(ctl), .rasN(memRasN), .casN(memCasN),
    .ceN(memCeN), .oeN(memOeN), .weN(memWeN)
  );

  mxdram_datapath #(
    .ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .DATA_BITS(DATA_BITS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .memAddr(memAddr), .memDqOut(memDqOut), .memDqDrive(memDqDrive),
    .memDqIn(memDqIn), .rdData(rdData), .rdValid(rdValid)
  );

endmodule

// File: tb/mxdram_ctrl_bench.sv
module mxdram_ctrl_bench;

  localparam int LAT    = 2;
  localparam int HOLD   = 2;
  localparam int PERIOD = 40;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [21:0] reqAddr = '0;
  logic [3:0]  reqWdata = '0;
  logic        reqReady, rdValid;
  logic [3:0]  rdData;
  logic [10:0] memAddr;
  logic        memRasN, memCasN, memCeN, memOeN, memWeN, memDqDrive;
  logic [3:0]  memDqOut;
  logic [3:0]  memDqIn;

  always #5 clk = ~clk;

  mxdram_ctrl #(.READ_LAT(LAT), .REF_HOLD(HOLD), .REFRESH_PERIOD(PERIOD)) u_mxdram_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rdData(rdData), .rdValid(rdValid), .memAddr(memAddr),
    .memRasN(memRasN), .memCasN(memCasN), .memCeN(memCeN), .memOeN(memOeN),
    .memWeN(memWeN), .memDqOut(memDqOut), .memDqDrive(memDqDrive),
    .memDqIn(memDqIn)
  );

  int checks = 0, fails = 0, cyc = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // ---------------- device model ----------------
  logic [3:0]  devMem [int];
  logic [3:0]  shadow [int];
  logic        prevRas = 1'b1, prevCas = 1'b1;
  logic [10:0] rowLatch = '0;
  logic        casSeen = 1'b0, oeWeSeen = 1'b0;
  logic [10:0] expRef = '0;
  int          refCount = 0;
  bit          wrapSeen = 0;
  logic [21:0] curAddr = '0;
  int          addrErr = 0, wrErr = 0, ceErr = 0, busyErr = 0, refRowErr = 0, refStrErr = 0;

  always @* begin
    memDqIn = 4'h0;
    if (!memOeN && !memCasN && devMem.exists(int'({rowLatch, memAddr})))
      memDqIn = devMem[int'({rowLatch, memAddr})];
  end

  always @(posedge clk) begin
    if (rstN) begin
      prevRas <= memRasN;
      prevCas <= memCasN;
      if (prevRas && !memRasN) begin
        rowLatch <= memAddr;
        casSeen  <= 1'b0;
        oeWeSeen <= 1'b0;
      end
      if (!memRasN && (!memOeN || !memWeN)) oeWeSeen <= 1'b1;
      if (!memRasN && !memCasN) casSeen <= 1'b1;
      if (prevCas && !memCasN) begin
        if ({rowLatch, memAddr} != curAddr) addrErr++;   // R2 pin split
        if (!memWeN) begin
          if (!memDqDrive) wrErr++;                     // R3
          devMem[int'({rowLatch, memAddr})] = memDqOut;
        end
      end
      if (!prevRas && memRasN && !casSeen) begin
        if (rowLatch != expRef) refRowErr++;            // R7
        if (oeWeSeen) refStrErr++;                      // R6
        if (expRef == 11'h7FF) wrapSeen = 1;
        expRef <= expRef + 1'b1;
        refCount++;
      end
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      if (!memRasN && memCeN) ceErr++;                  // R9
      if (!memRasN && reqReady) busyErr++;              // R8
    end
  end

  // ---------------- scoreboard ----------------
  logic [3:0] expData [$];
  int         expCyc  [$];

  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (expData.size() == 0) chk(0, "R4 unexpected rdValid", 1, 0);
      else begin
        logic [3:0] d;
        int c;
        d = expData.pop_front();
        c = expCyc.pop_front();
        chk(rdData == d, "R4 read data", rdData, d);
        chk(cyc - c == LAT + 3, "R4 read latency", cyc - c, LAT + 3);
      end
    end
  end

  // ---------------- driver ----------------
  task automatic hostOp(input bit wr, input logic [21:0] a, input logic [3:0] d, input bit chkBusy);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    while (!reqReady) @(negedge clk);
    curAddr = a;
    @(negedge clk);
    reqValid = 1'b0;
    if (wr) shadow[int'(a)] = d;
    else begin
      expData.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : 4'h0);
      expCyc.push_back(cyc);
    end
    if (chkBusy) chk(!reqReady, "R5 ready low after accept", reqReady, 0);
    while (!reqReady) @(negedge clk);
  endtask

  logic [21:0] addrs [6] = '{22'h000000, 22'h3FFFFF, 22'h1B0007, 22'h000800, 22'h0007FF, 22'h2AA555};

  initial begin
    repeat (3) @(negedge clk);
    chk({memRasN, memCasN, memWeN, memOeN, memCeN} == 5'h1F, "R1 strobes in reset",
        {memRasN, memCasN, memWeN, memOeN, memCeN}, 5'h1F);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady == 1'b1, "R1 ready after reset", reqReady, 1);
    chk(rdValid == 1'b0 && memDqDrive == 1'b0, "R1 rdValid/drive idle", {rdValid, memDqDrive}, 0);
    chk(memCeN == 1'b1, "R9 chip disabled when idle", memCeN, 1);

    // R2 R3 R4: distinct address patterns, write then read back
    foreach (addrs[i]) hostOp(1'b1, addrs[i], 4'(i * 5 + 3), 1'b1);
    foreach (addrs[i]) hostOp(1'b0, addrs[i], 4'h0, 1'b1);
    // overwrite and reread one location
    hostOp(1'b1, 22'h1B0007, 4'hA, 1'b0);
    hostOp(1'b0, 22'h1B0007, 4'h0, 1'b0);

    // R8: flood of back-to-back transfers across several refresh periods
    begin
      int r0;
      r0 = refCount;
      for (int k = 0; k < 120; k++) begin
        logic [21:0] a;
        a = 22'((k * 40503) ^ (k << 13));
        hostOp(1'b1, a, 4'(k), 1'b0);
        hostOp(1'b0, a, 4'h0, 1'b0);
      end
      chk(refCount > r0, "R8 refresh served during host flood", refCount - r0, 1);
    end
    repeat (10) @(negedge clk);
    chk(expData.size() == 0, "R4 all reads returned", expData.size(), 0);

    // R6: idle refresh rate
    begin
      int r1;
      r1 = refCount;
      repeat (PERIOD * 50) @(negedge clk);
      chk((refCount - r1) >= 49 && (refCount - r1) <= 51, "R6 refresh rate", refCount - r1, 50);
    end

    // R7: wait until the row counter has wrapped
    while (refCount < 2052) @(negedge clk);
    chk(wrapSeen, "R7 refresh row wrap past 2047", wrapSeen, 1);
    chk(refRowErr == 0, "R7 refresh row sequence", refRowErr, 0);
    chk(refStrErr == 0, "R6 refresh is row-strobe only", refStrErr, 0);
    chk(addrErr == 0, "R2 row/column halves on pins", addrErr, 0);
    chk(wrErr == 0, "R3 data driven at column strobe", wrErr, 0);
    chk(ceErr == 0, "R9 chip enable during cycles", ceErr, 0);
    chk(busyErr == 0, "R8 ready low while row strobe low", busyErr, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    chk(0, "watchdog expired", cyc, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule